// File: doc/BRIEF.md
# Endian-Configurable Word Memory Port

This block holds a small byte-addressed store and gives it one word-wide access port. Every stored byte sits at its own address. An access moves a group of 1, 2, 4 or 8 consecutive bytes that starts at the given byte address. A mode input sets the byte order at run time. In little-endian mode the lowest address holds the least-significant byte of the word. In big-endian mode the lowest address holds the most-significant byte. The same stored bytes can therefore be read back in either order.

Every access is checked for natural alignment, which means the byte address must be a multiple of the access size. A policy input decides what happens to a misaligned access. Under the strict policy the access is refused and flagged. Under the lenient policy it is performed like any other access. Reads are registered, so results appear one clock after the access. A chip enable gates all activity.

Top module: `endian_word_port`

## Requirements
- R1: After reset, `rdata` and `misalign` are zero and every byte of the store reads as zero.
- R2: `size` selects the access width in bytes as 1 << size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. The bytes touched are addr, addr+1, …, addr+N−1.
- R3: With `big_en` = 0, the byte at addr+i carries data bits [8i+7:8i].
- R4: With `big_en` = 1, the byte at addr+i carries data bits [8(N−1−i)+7 : 8(N−1−i)].
- R5: An enabled read (`ce`=1, `we`=0) updates `rdata` on the next clock edge. Bits at and above 8N are zero.
- R6: An access is aligned exactly when addr is a multiple of N. An aligned access never raises `misalign`.
- R7: When `strict`=1, a misaligned enabled access sets `misalign` to 1 on the next edge, leaves the store unchanged and drives `rdata` to zero.
- R8: When `strict`=0, a misaligned access is carried out normally with `misalign` = 0. Byte addresses wrap modulo 2^ADDR_W.
- R9: While `ce`=0, no access is made, the store is unchanged, and `rdata` and `misalign` hold their values.
- R10: An accepted write updates the store and leaves `rdata` unchanged.
- R11: After the 4-byte word 0xF498B70F is written at address 0, a 1-byte read of address 0 returns 0xF4 when the word was written in big-endian order and 0x0F when it was written in little-endian order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable; no access while low |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address of the first byte |
| size | input | 2 | Access width code, N = 1 << size bytes |
| big_en | input | 1 | 1 = big-endian, 0 = little-endian |
| strict | input | 1 | 1 = refuse misaligned accesses |
| wdata | input | 64 | Write data, low 8N bits used |
| rdata | output | 64 | Registered read data |
| misalign | output | 1 | Registered alignment fault |

## Verification
A wrong lane mapping or a wrong address offset puts a byte in the wrong place in the store. This shows up on `rdata` one cycle after the next read that covers that byte, which is why every write is followed at once by reads of the same span in both byte orders and at byte width. A store that was corrupted by a refused or disabled access, rather than a wrong output, only shows up when the affected bytes are read. The sweep reads back after every write to catch it within two accesses. A fault flag that is wrong appears on `misalign` one edge after the access.

// File: rtl/endian_word_port.sv
module endian_word_port #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              big_en,
  input  logic              strict,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  output logic              misalign
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = 8;

  logic [7:0]        mem [DEPTH];
  logic [3:0]        nbytes;
  logic              aligned, fault;
  logic [ADDR_W-1:0] lane_addr [LANES];
  logic [2:0]        lane_sig  [LANES];
  logic [63:0]       rd_word;

  assign nbytes  = 4'd1 << size;
  assign aligned = (addr & ADDR_W'(nbytes - 4'd1)) == '0;
  assign fault   = strict && !aligned;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < LANES; i++) begin
      lane_addr[i] = addr + ADDR_W'(i);
      lane_sig[i]  = big_en ? 3'(nbytes - 4'd1 - 4'(i)) : 3'(i);
      if (4'(i) < nbytes)
        rd_word[lane_sig[i]*8 +: 8] = mem[lane_addr[i]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      misalign <= 1'b0;
      for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
    end else if (ce) begin
      misalign <= fault;
      if (fault) begin
        rdata <= '0;
      end else if (we) begin
        for (int i = 0; i < LANES; i++)
          if (4'(i) < nbytes)
            mem[lane_addr[i]] <= wdata[lane_sig[i]*8 +: 8];
      end else begin
        rdata <= rd_word;
      end
    end
  end
endmodule

// File: rtl/endian_word_port_chk.sv
module endian_word_port_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        size,
  input logic              big_en,
  input logic              strict,
  input logic [63:0]       wdata,
  input logic [63:0]       rdata,
  input logic              misalign
);
  logic on_grid;
  assign on_grid = (int'(addr) % (1 << int'(size))) == 0;

  p_aligned_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ce && on_grid |=> !misalign);

  p_strict_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ce && strict && !on_grid |=> misalign && rdata == 64'd0);

  p_lenient_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !strict |=> !misalign);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(rdata) && $stable(misalign));

  p_write_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce && we && !(strict && !on_grid) |=> $stable(rdata));

  p_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !we && size == 2'd1 |=> rdata[63:16] == 48'd0);
endmodule

bind endian_word_port endian_word_port_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/endian_word_port_test.sv
module endian_word_port_test;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, ce = 0, we = 0, big_en = 0, strict = 0;
  logic [AW-1:0] addr = '0;
  logic [1:0] size = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic misalign;

  int total = 0, bad = 0;
  logic [7:0] ref_mem [DEPTH];
  logic [63:0] exp_rd = '0;
  logic exp_mis = 0;

  always #2 clk = ~clk;

  endian_word_port #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr), .size(size),
    .big_en(big_en), .strict(strict), .wdata(wdata), .rdata(rdata),
    .misalign(misalign));

  task automatic check(string tag);
    total++;
    if (rdata !== exp_rd || misalign !== exp_mis) begin
      bad++;
      $display("FAIL %s: rdata=%h mis=%b expected rdata=%h mis=%b",
               tag, rdata, misalign, exp_rd, exp_mis);
    end
  endtask

  task automatic op(input logic c, input logic w, input int a, input int sz,
                    input logic be, input logic st, input logic [63:0] wd,
                    input string tag);
    int nb;
    bit fl;
    @(negedge clk);
    ce = c; we = w; addr = AW'(a); size = 2'(sz); big_en = be; strict = st; wdata = wd;
    nb = 1 << sz;
    fl = st && (a % nb) != 0;
    if (c) begin
      exp_mis = fl;
      if (fl) exp_rd = '0;
      else if (w) begin
        for (int i = 0; i < nb; i++)
          ref_mem[(a + i) % DEPTH] = be ? wd[8*(nb-1-i) +: 8] : wd[8*i +: 8];
      end else begin
        exp_rd = '0;
        for (int i = 0; i < nb; i++) begin
          if (be) exp_rd[8*(nb-1-i) +: 8] = ref_mem[(a + i) % DEPTH];
          else    exp_rd[8*i +: 8]        = ref_mem[(a + i) % DEPTH];
        end
      end
    end
    @(posedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < DEPTH; d++) ref_mem[d] = '0;
    #5;
    check("R1 reset outputs");
    rst_n = 1;
    for (int d = 0; d < DEPTH; d++) op(1, 0, d, 0, 0, 0, '0, "R1 store cleared");

    op(1, 1, 0, 2, 1, 1, 64'hF498B70F, "R11 write big-endian");
    op(1, 0, 0, 0, 0, 1, '0, "R11 byte0 big-endian = F4");
    op(1, 1, 0, 2, 0, 1, 64'hF498B70F, "R11 write little-endian");
    op(1, 0, 0, 0, 0, 1, '0, "R11 byte0 little-endian = 0F");

    op(1, 0, 0, 3, 0, 0, '0, "R5 read before disable");
    op(0, 1, 0, 3, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R9 disabled write holds outputs");
    op(0, 0, 3, 1, 0, 1, '0, "R9 disabled misaligned holds outputs");
    op(1, 0, 0, 3, 0, 0, '0, "R9 store unchanged after disabled write");

    for (int be = 0; be < 2; be++)
      for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 4; sz++)
          for (int a = 0; a < DEPTH; a++) begin
            logic [63:0] pat;
            string t;
            pat = {32'(a * 32'h9E3779B9 + sz * 7 + be), 32'(a * 32'h7F4A7C15 + st * 13 + 1)};
            if ((a % (1 << sz)) != 0)
              t = st ? "R7 strict misaligned" : "R8 lenient misaligned/wrap";
            else
              t = be ? "R4 big-endian aligned R6" : "R3 little-endian aligned R6";
            op(1, 1, a, sz, 1'(be), 1'(st), pat, {t, " write R10"});
            op(1, 0, a, sz, 1'(be), 1'(st), '0, {t, " readback R2 R5"});
            op(1, 0, a, sz, 1'(!be), 1'(st), '0, {t, " opposite order R3 R4"});
            op(1, 0, a, 0, 0, 1'(st), '0, {t, " byte view R2"});
          end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule